// File: doc/BRIEF.md
# Board Control Register Interrupt Aggregator

This block is the register bank of a board-level companion logic device, reached over a simple synchronous bus inside a 1 MB address window. It holds a set of plain 32-bit storage registers: two LED data words, an LED control word, a switch word, three miscellaneous write words, a miscellaneous read word that is also writable, and two card-slot words. Each of these reads back whatever was last written to it.

The block also merges sixteen external interrupt lines into a single interrupt toward the host. An enable register chooses which lines take part. A status register records the line that last changed among the enabled ones, as a one-hot value. The host interrupt follows the new level of that line. The block samples the lines once per clock and keeps a record of the level of every line, whether or not the line is enabled.

Top module: `brd_ctl_irq_hub`

## Requirements
- R1: A synchronous active-low reset clears every register, the level record, the read data and the host interrupt to zero.
- R2: Writes to the storage registers at offsets 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88, 0x90, 0xE0 and 0xE4 keep all 32 bits. A read with `bus_rd` high shows the stored value on `bus_rdata` after the next clock edge.
- R3: Writes to the enable register (offset 0xC0) and to the status register (offset 0xD0) store only the written value ANDed with 0x000FEEFF. Because of this, lines 8 and 12 can never be enabled.
- R4: A read from any other 20-bit offset returns zero. A write to any other offset changes no register.
- R5: When an enabled line changes level, the status register becomes the one-hot value of that line's bit in the next cycle.
- R6: When an enabled line changes level, `irq_host` takes that line's new level in the next cycle.
- R7: A change on a line that is not enabled leaves both the status register and `irq_host` unchanged.
- R8: When several enabled lines change in the same cycle, the highest-numbered one sets both the status value and the `irq_host` level.
- R9: If an enabled line changes in the same cycle as a bus write to the status register, the captured one-hot value wins.
- R10: The level record follows every line, enabled or not. Enabling a line that changed while it was disabled therefore captures nothing until that line changes again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 20 | Byte offset inside the window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered |
| irq_in | input | 16 | External interrupt lines |
| irq_host | output | 1 | Interrupt toward the host |

## Verification
Any fault in the level record or in the enable register appears as a missing or a phantom capture. It is visible on `irq_host` one edge after the line moves, and in the status register on the read that follows. The checks that drive lines while they are disabled and then enable them show stale level history. The checks that move several lines at once, including lines with opposite levels, show a wrong priority. Decode faults show as aliasing: the bench writes every register first, then writes to unmapped offsets, and only then reads everything back.

// File: rtl/brd_ctl_pkg.sv
// Package: shared sizes and the register offset map of the aggregator.
// Assumes byte offsets inside a 1 MB window; one register per offset.
package brd_ctl_pkg;
    localparam int ADDR_W = 20;
    localparam int DATA_W = 32;
    localparam int N_IRQ  = 16;
    localparam int N_REG  = 12;
    localparam int N_GP   = N_REG - 2;
    localparam logic [31:0] IRQ_WMASK = 32'h000F_EEFF;

    // Index 0 is the enable register, index 1 the status register,
    // the rest are plain storage.
    function automatic logic [31:0] reg_offset(input int idx);
        case (idx)
            0:       return 32'hC0;
            1:       return 32'hD0;
            2:       return 32'hE0;
            3:       return 32'hE4;
            4:       return 32'h10;
            5:       return 32'h14;
            6:       return 32'h40;
            7:       return 32'h60;
            8:       return 32'h80;
            9:       return 32'h84;
            10:      return 32'h88;
            default: return 32'h90;
        endcase
    endfunction
endpackage

// File: rtl/brd_addr_dec.sv
// Address decoder: one select line per register, exact match on the offset.
// Assumes offsets from brd_ctl_pkg::reg_offset are distinct.
module brd_addr_dec #(
    parameter int ADDR_W = 20,
    parameter int N_REG  = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [N_REG-1:0]  sel
);
    // Compare the address against each offset.
    for (genvar i = 0; i < N_REG; i++) begin : g_sel
        assign sel[i] = (addr == ADDR_W'(brd_ctl_pkg::reg_offset(i)));
    end
endmodule

// File: rtl/brd_gp_regs.sv
// Plain storage registers: full-width write, no side effects.
// Assumes at most one select line is high at a time.
module brd_gp_regs #(
    parameter int DATA_W = 32,
    parameter int N_GP   = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [N_GP-1:0]              sel,
    input  logic [DATA_W-1:0]            wdata,
    output logic [N_GP-1:0][DATA_W-1:0]  gp_q
);
    for (genvar i = 0; i < N_GP; i++) begin : g_reg
        // Store the whole word on a selected write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                gp_q[i] <= '0;
            else if (we && sel[i])
                gp_q[i] <= wdata;
        end
    end
endmodule

// File: rtl/brd_irq_capture.sv
// Interrupt capture: level record, enable register, one-hot status and
// host interrupt. The highest-numbered enabled changing line wins, and a
// capture takes priority over a bus write to status in the same cycle.
// Assumes irq_in is synchronous to clk.
module brd_irq_capture #(
    parameter int          DATA_W = 32,
    parameter int          N_IRQ  = 16,
    parameter logic [31:0] WMASK  = 32'h000F_EEFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IRQ-1:0]  irq_in,
    input  logic              mask_we,
    input  logic              stat_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] stat_q,
    output logic              irq_host
);
    localparam int IDX_W = $clog2(N_IRQ);
    localparam logic [DATA_W-1:0] WM = DATA_W'(WMASK);

    logic [N_IRQ-1:0]  lvl_q;
    logic [N_IRQ-1:0]  hit;
    logic [IDX_W-1:0]  top_idx;
    logic              found;
    logic [DATA_W-1:0] onehot;

    assign hit = (irq_in ^ lvl_q) & mask_q[N_IRQ-1:0];

    // Pick the highest-numbered enabled line that changed.
    always_comb begin
        top_idx = '0;
        found   = 1'b0;
        for (int k = 0; k < N_IRQ; k++) begin
            if (hit[k]) begin
                top_idx = IDX_W'(k);
                found   = 1'b1;
            end
        end
        onehot          = '0;
        onehot[top_idx] = 1'b1;
    end

    // Track the level of every line, enabled or not.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= irq_in;
    end

    // Enable register, filtered through the write mask.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= wdata & WM;
    end

    // Status: a capture beats a bus write.
    always_ff @(posedge clk) begin
        if (!rst_n)       stat_q <= '0;
        else if (found)   stat_q <= onehot;
        else if (stat_we) stat_q <= wdata & WM;
    end

    // Host interrupt follows the captured line's new level.
    always_ff @(posedge clk) begin
        if (!rst_n)     irq_host <= 1'b0;
        else if (found) irq_host <= irq_in[top_idx];
    end

    // R3
    mask_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (mask_q == ($past(wdata) & WM)));
    // R5
    stat_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> ($countones(stat_q) == 1));
    // R6
    host_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> (irq_host == |(lvl_q & stat_q[N_IRQ-1:0])));
    // R7
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|hit) && !stat_we) |=> ($stable(stat_q) && $stable(irq_host)));
endmodule

// File: rtl/brd_ctl_irq_hub.sv
// Top: register bank with interrupt aggregation on a simple synchronous bus.
// Read data is registered and updates only on a read strobe.
// Assumes bus_wr and bus_rd are single-cycle strobes.
module brd_ctl_irq_hub #(
    parameter int          ADDR_W = brd_ctl_pkg::ADDR_W,
    parameter int          DATA_W = brd_ctl_pkg::DATA_W,
    parameter int          N_IRQ  = brd_ctl_pkg::N_IRQ,
    parameter logic [31:0] WMASK  = brd_ctl_pkg::IRQ_WMASK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_IRQ-1:0]  irq_in,
    output logic              irq_host
);
    localparam int N_REG = brd_ctl_pkg::N_REG;
    localparam int N_GP  = N_REG - 2;

    logic [N_REG-1:0]              sel;
    logic [N_GP-1:0][DATA_W-1:0]   gp_q;
    logic [DATA_W-1:0]             mask_q, stat_q, rd_val;

    brd_addr_dec #(.ADDR_W(ADDR_W), .N_REG(N_REG)) i_dec (
        .addr(bus_addr), .sel(sel));

    brd_gp_regs #(.DATA_W(DATA_W), .N_GP(N_GP)) i_gp (
        .clk(clk), .rst_n(rst_n), .we(bus_wr), .sel(sel[N_REG-1:2]),
        .wdata(bus_wdata), .gp_q(gp_q));

    brd_irq_capture #(.DATA_W(DATA_W), .N_IRQ(N_IRQ), .WMASK(WMASK)) i_irq (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .mask_we(bus_wr && sel[0]), .stat_we(bus_wr && sel[1]),
        .wdata(bus_wdata), .mask_q(mask_q), .stat_q(stat_q),
        .irq_host(irq_host));

    // Read mux: OR of selected registers, zero when nothing matches.
    always_comb begin
        rd_val = ({DATA_W{sel[0]}} & mask_q) | ({DATA_W{sel[1]}} & stat_q);
        for (int i = 0; i < N_GP; i++)
            rd_val = rd_val | ({DATA_W{sel[i+2]}} & gp_q[i]);
    end

    // Register the read data on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val;
    end

    // R4
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !(|sel)) |=> (bus_rdata == '0));
    // R2
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/test_brd_ctl_irq_hub.sv
module test_brd_ctl_irq_hub;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [15:0] irq_in = '0;
    logic        irq_host;

    int total = 0;
    int bad = 0;
    logic [31:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    brd_ctl_irq_hub i_brd_ctl_irq_hub (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .irq_host(irq_host));

    // Register vectors: mapped entries first, then unmapped ones.
    localparam logic [19:0] T_ADDR [NV] = '{
        20'h10, 20'h14, 20'h40, 20'h60, 20'h80, 20'h84, 20'h88, 20'h90,
        20'hC0, 20'hD0, 20'hE0, 20'hE4, 20'h11, 20'hC4, 20'h80010};
    localparam logic [31:0] T_WD [NV] = '{
        32'hA1A1_0001, 32'hB2B2_0002, 32'hC3C3_0003, 32'hD4D4_0004,
        32'hE5E5_0005, 32'hF6F6_0006, 32'h1717_0007, 32'h2828_0008,
        32'hFFFF_FFFF, 32'h1234_5678, 32'h3939_0009, 32'h4A4A_000A,
        32'h5B5B_0011, 32'h6C6C_00C4, 32'h7D7D_0010};
    localparam logic [31:0] T_EXP [NV] = '{
        32'hA1A1_0001, 32'hB2B2_0002, 32'hC3C3_0003, 32'hD4D4_0004,
        32'hE5E5_0005, 32'hF6F6_0006, 32'h1717_0007, 32'h2828_0008,
        32'h000F_EEFF, 32'h0004_4678, 32'h3939_0009, 32'h4A4A_000A,
        32'h0, 32'h0, 32'h0};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [19:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [19:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    // Move the lines, let one edge capture, then check host and status.
    task automatic irq_step(input logic [15:0] v, input logic [31:0] stat_exp,
                            input logic host_exp, input string req);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
        chk({req, " host"}, {31'b0, irq_host}, {31'b0, host_exp});
        do_rd(20'hD0, rv);
        chk({req, " status"}, rv, stat_exp);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got=expired exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 host", {31'b0, irq_host}, 32'h0);
        do_rd(20'hC0, rv); chk("R1 mask", rv, 32'h0);
        do_rd(20'hD0, rv); chk("R1 status", rv, 32'h0);
        do_rd(20'h10, rv); chk("R1 led", rv, 32'h0);

        // R2 R3 R4: write all, then read all back
        for (int i = 0; i < NV; i++) do_wr(T_ADDR[i], T_WD[i]);
        for (int i = 0; i < NV; i++) begin
            do_rd(T_ADDR[i], rv);
            chk(i >= 12 ? "R4 unmapped" : (i == 8 || i == 9) ? "R3 filter" : "R2 store",
                rv, T_EXP[i]);
        end

        // R3: enable all, bits 8 and 12 filtered off
        do_wr(20'hC0, 32'h0000_FFFF);
        do_rd(20'hC0, rv); chk("R3 mask", rv, 32'h0000_EEFF);

        // R5 R6: line 3 rises
        irq_step(16'h0008, 32'h8, 1'b1, "R5 R6 rise");
        // R7: line 8 is disabled
        irq_step(16'h0108, 32'h8, 1'b1, "R7 disabled");
        // R6: line 3 falls
        irq_step(16'h0100, 32'h8, 1'b0, "R6 fall");

        // R10: line 5 moves while disabled, then is enabled
        do_wr(20'hC0, 32'h0000_EEDF);
        irq_step(16'h0120, 32'h8, 1'b0, "R10 disabled rise");
        do_wr(20'hC0, 32'h0000_EEFF);
        chk("R10 enable host", {31'b0, irq_host}, 32'h0);
        do_rd(20'hD0, rv); chk("R10 enable status", rv, 32'h8);
        irq_step(16'h0100, 32'h20, 1'b0, "R10 later fall");

        // R8: simultaneous changes
        irq_step(16'h0304, 32'h200, 1'b1, "R8 two rise");
        irq_step(16'h0105, 32'h200, 1'b0, "R8 high falls");
        irq_step(16'h4101, 32'h4000, 1'b1, "R8 mixed");

        // R9: capture and status write in the same cycle
        @(negedge clk);
        bus_addr = 20'hD0; bus_wdata = 32'hFFFF; bus_wr = 1'b1; irq_in = 16'h4103;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R9 host", {31'b0, irq_host}, 32'h1);
        do_rd(20'hD0, rv); chk("R9 status", rv, 32'h2);

        // R3 status write alone, R7 host untouched
        do_wr(20'hD0, 32'h0000_FFFF);
        do_rd(20'hD0, rv); chk("R3 status write", rv, 32'h0000_EEFF);
        irq_step(16'h5103, 32'h0000_EEFF, 1'b1, "R7 line12");

        // R1: reset in the middle of a run
        @(negedge clk);
        irq_in = '0; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 rerun host", {31'b0, irq_host}, 32'h0);
        do_rd(20'hC0, rv); chk("R1 rerun mask", rv, 32'h0);
        do_rd(20'hD0, rv); chk("R1 rerun status", rv, 32'h0);
        do_rd(20'h90, rv); chk("R1 rerun misc", rv, 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule